// File: doc/BRIEF.md
# Extender-Based Ripple ALU

This block is an N-bit arithmetic logic unit made of one identical slice per bit. Each slice has three parts. A logic extender shapes the first adder input. An arithmetic extender shapes the second adder input. A full adder combines the two with the carry from the slice below. Carries ripple from bit 0 upward. A mode input chooses between arithmetic and logic work. Two select inputs then pick one of four operations within that mode, so the block offers eight operations in total.

Arithmetic operations never touch the first operand. They only reshape the second operand and the initial carry, so decrement, add, subtract and increment all share the same adder. Logic operations are formed bit by bit in the logic extender. The second adder input and the carry are held at zero, so the adder simply passes the logic value through.

An optional output pipeline of `LATENCY` register stages delays the result, the carry-out and a valid flag together. A second parameter chooses how the logic gates are built: as plain gates, or as three-input majority gates with one input tied to a constant.

Top module: `ext_ripple_alu`

## Requirements
- R1: When `arith_mode`=1 the block performs arithmetic; when it is 0 the block performs logic. The 2-bit operation code is {`sel_hi`,`sel_lo`}.
- R2: The arithmetic codes give these results, all modulo 2^WIDTH: 00 gives A-1, 01 gives A+B, 10 gives A-B, 11 gives A+1.
- R3: In arithmetic mode `carry_out` is the carry leaving the top bit of A+Y+cin. Here Y is all ones, B, ~B or zero, and cin is 1 only for codes 10 and 11. So decrement gives 1 unless A=0, add gives the true carry, subtract gives 1 exactly when A>=B, and increment gives 1 exactly when A is all ones.
- R4: The logic codes give these results: 00 gives ~A, 01 gives A&B, 10 gives A, 11 gives A|B. In logic mode `carry_out` is 0.
- R5: Both gate forms (`GATE_STYLE`=0 for plain gates, 1 for majority gates) produce identical `result` and `carry_out` for every input.
- R6: `result`, `carry_out` and `out_valid` appear exactly `LATENCY` clock cycles after the inputs and `in_valid` are sampled. With `LATENCY`=0 the path is combinational.
- R7: A synchronous active-high `rst` clears every pipeline stage, so `out_valid`, `result` and `carry_out` read 0 while reset is held (`LATENCY`>0).
- R8: One operation is accepted every cycle, and results leave in the order the operations were issued, with none lost or added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output pipeline |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the inputs of this cycle as an operation |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| arith_mode | input | 1 | 1 for arithmetic, 0 for logic |
| sel_hi | input | 1 | Upper bit of the operation code |
| sel_lo | input | 1 | Lower bit of the operation code |
| out_valid | output | 1 | Result of this cycle is valid |
| result | output | WIDTH | Operation result |
| carry_out | output | 1 | Carry from the most significant slice |

## Verification
A wrong extender output in one slice shows up at once as a wrong `result` bit, but only for the opcodes that use that extender value. A carry fault shows in the bits above the faulty slice and in `carry_out`, and only for operand pairs that make that carry propagate. For this reason the narrow instance sweeps every operand pair under all eight codes. A corrupted pipeline stage appears exactly `LATENCY` cycles later as a valid flag or data word that does not match what the scoreboard expects.

// File: rtl/alu_ext_pkg.sv
package alu_ext_pkg;

   // operation codes {sel_hi, sel_lo}
   localparam logic [1:0] OPC_ARI_DEC  = 2'b00;
   localparam logic [1:0] OPC_ARI_ADD  = 2'b01;
   localparam logic [1:0] OPC_ARI_SUB  = 2'b10;
   localparam logic [1:0] OPC_ARI_INC  = 2'b11;
   localparam logic [1:0] OPC_LOG_NOT  = 2'b00;
   localparam logic [1:0] OPC_LOG_AND  = 2'b01;
   localparam logic [1:0] OPC_LOG_PASS = 2'b10;
   localparam logic [1:0] OPC_LOG_OR   = 2'b11;

   localparam int GATES_PLAIN    = 0;
   localparam int GATES_MAJORITY = 1;

   function automatic logic maj3(input logic p, input logic q, input logic r);
      return (p & q) | (p & r) | (q & r);
   endfunction

endpackage

// File: rtl/alu_logic_ext.sv
module alu_logic_ext
   import alu_ext_pkg::*;
#(
   parameter int GATE_STYLE = GATES_PLAIN
) (
   input  logic       a_bit,
   input  logic       b_bit,
   input  logic       arith,
   input  logic [1:0] opc,
   output logic       x_bit
);

   logic and_v;
   logic or_v;

   generate
      if (GATE_STYLE == GATES_MAJORITY) begin : g_maj
         assign and_v = maj3(a_bit, b_bit, 1'b0);
         assign or_v  = maj3(a_bit, b_bit, 1'b1);
      end else begin : g_plain
         assign and_v = a_bit & b_bit;
         assign or_v  = a_bit | b_bit;
      end
   endgenerate

   always_comb begin
      if (arith) begin
         x_bit = a_bit;
      end else begin
         unique case (opc)
            OPC_LOG_NOT:  x_bit = ~a_bit;
            OPC_LOG_AND:  x_bit = and_v;
            OPC_LOG_PASS: x_bit = a_bit;
            default:      x_bit = or_v;
         endcase
      end
   end

endmodule

// File: rtl/alu_arith_ext.sv
module alu_arith_ext
   import alu_ext_pkg::*;
(
   input  logic       b_bit,
   input  logic       arith,
   input  logic [1:0] opc,
   output logic       y_bit
);

   always_comb begin
      if (!arith) begin
         y_bit = 1'b0;
      end else begin
         unique case (opc)
            OPC_ARI_DEC: y_bit = 1'b1;
            OPC_ARI_ADD: y_bit = b_bit;
            OPC_ARI_SUB: y_bit = ~b_bit;
            default:     y_bit = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/alu_full_add.sv
module alu_full_add
   import alu_ext_pkg::*;
#(
   parameter int GATE_STYLE = GATES_PLAIN
) (
   input  logic x_bit,
   input  logic y_bit,
   input  logic c_in,
   output logic s_bit,
   output logic c_out
);

   logic half;
   assign half  = x_bit ^ y_bit;
   assign s_bit = half ^ c_in;

   generate
      if (GATE_STYLE == GATES_MAJORITY) begin : g_maj
         assign c_out = maj3(x_bit, y_bit, c_in);
      end else begin : g_plain
         assign c_out = (x_bit & y_bit) | (c_in & half);
      end
   endgenerate

endmodule

// File: rtl/alu_slice.sv
module alu_slice
   import alu_ext_pkg::*;
#(
   parameter int GATE_STYLE = GATES_PLAIN
) (
   input  logic       a_bit,
   input  logic       b_bit,
   input  logic       arith,
   input  logic [1:0] opc,
   input  logic       c_in,
   output logic       s_bit,
   output logic       c_out
);

   logic x_bit;
   logic y_bit;

   alu_logic_ext #(.GATE_STYLE(GATE_STYLE)) i_lext (
      .a_bit (a_bit),
      .b_bit (b_bit),
      .arith (arith),
      .opc   (opc),
      .x_bit (x_bit)
   );

   alu_arith_ext i_aext (
      .b_bit (b_bit),
      .arith (arith),
      .opc   (opc),
      .y_bit (y_bit)
   );

   alu_full_add #(.GATE_STYLE(GATE_STYLE)) i_fa (
      .x_bit (x_bit),
      .y_bit (y_bit),
      .c_in  (c_in),
      .s_bit (s_bit),
      .c_out (c_out)
   );

endmodule

// File: rtl/alu_out_pipe.sv
module alu_out_pipe #(
   parameter int WIDTH   = 8,
   parameter int LATENCY = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             v_in,
   input  logic [WIDTH-1:0] f_in,
   input  logic             c_in,
   output logic             v_out,
   output logic [WIDTH-1:0] f_out,
   output logic             c_out
);

   localparam int SW = WIDTH + 2;

   generate
      if (LATENCY == 0) begin : g_comb
         assign v_out = v_in;
         assign f_out = f_in;
         assign c_out = c_in;
      end else begin : g_regs
         logic [SW-1:0] stage [LATENCY];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < LATENCY; i++) stage[i] <= '0;
            end else begin
               stage[0] <= {v_in, c_in, f_in};
               for (int i = 1; i < LATENCY; i++) stage[i] <= stage[i-1];
            end
         end
         assign v_out = stage[LATENCY-1][SW-1];
         assign c_out = stage[LATENCY-1][SW-2];
         assign f_out = stage[LATENCY-1][WIDTH-1:0];
      end
   endgenerate

endmodule

// File: rtl/ext_ripple_alu.sv
module ext_ripple_alu
   import alu_ext_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter int LATENCY    = 0,
   parameter int GATE_STYLE = GATES_PLAIN
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             arith_mode,
   input  logic             sel_hi,
   input  logic             sel_lo,
   output logic             out_valid,
   output logic [WIDTH-1:0] result,
   output logic             carry_out
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("ext_ripple_alu: WIDTH must be at least 1");
      end
      if (LATENCY < 0) begin : g_bad_lat
         $error("ext_ripple_alu: LATENCY must not be negative");
      end
      if (GATE_STYLE != GATES_PLAIN && GATE_STYLE != GATES_MAJORITY) begin : g_bad_style
         $error("ext_ripple_alu: unknown GATE_STYLE");
      end
   endgenerate

   logic [1:0]       opc;
   logic [WIDTH:0]   carry;
   logic [WIDTH-1:0] comb_f;
   logic             comb_cout;

   assign opc      = {sel_hi, sel_lo};
   // carry into bit 0 set only for subtract and increment
   assign carry[0] = arith_mode & sel_hi;

   generate
      for (genvar k = 0; k < WIDTH; k++) begin : g_slice
         alu_slice #(.GATE_STYLE(GATE_STYLE)) i_slice (
            .a_bit (op_a[k]),
            .b_bit (op_b[k]),
            .arith (arith_mode),
            .opc   (opc),
            .c_in  (carry[k]),
            .s_bit (comb_f[k]),
            .c_out (carry[k+1])
         );
      end
   endgenerate

   assign comb_cout = carry[WIDTH];

   alu_out_pipe #(.WIDTH(WIDTH), .LATENCY(LATENCY)) i_pipe (
      .clk   (clk),
      .rst   (rst),
      .v_in  (in_valid),
      .f_in  (comb_f),
      .c_in  (comb_cout),
      .v_out (out_valid),
      .f_out (result),
      .c_out (carry_out)
   );

endmodule

// File: rtl/alu_ext_checks.sv
module alu_ext_checks #(
   parameter int WIDTH   = 8,
   parameter int LATENCY = 0
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic             arith_mode,
   input logic             sel_hi,
   input logic             sel_lo,
   input logic             out_valid,
   input logic [WIDTH-1:0] comb_f,
   input logic             comb_cout
);

   logic [WIDTH:0] add_ref;
   logic [WIDTH:0] sub_ref;
   assign add_ref = {1'b0, op_a} + {1'b0, op_b};
   assign sub_ref = {1'b0, op_a} + {1'b0, ~op_b} + 1'b1;

   // R4: logic mode never produces a carry
   a_r4_logic_no_carry: assert property (@(posedge clk) disable iff (rst)
      !arith_mode |-> !comb_cout);

   // R4: identity code passes A
   a_r4_identity: assert property (@(posedge clk) disable iff (rst)
      (!arith_mode && sel_hi && !sel_lo) |-> comb_f == op_a);

   // R2/R3: add code matches wide sum
   a_r2_add: assert property (@(posedge clk) disable iff (rst)
      (arith_mode && !sel_hi && sel_lo) |-> {comb_cout, comb_f} == add_ref);

   // R3: subtract code, carry set exactly when no borrow
   a_r3_sub: assert property (@(posedge clk) disable iff (rst)
      (arith_mode && sel_hi && !sel_lo) |-> {comb_cout, comb_f} == sub_ref);

   // R1: mode bit alone flips increment vs OR on zero operands
   a_r1_inc_zero: assert property (@(posedge clk) disable iff (rst)
      (arith_mode && sel_hi && sel_lo && op_a == '0) |-> comb_f == WIDTH'(1));

   generate
      if (LATENCY >= 1) begin : g_reg
         // R7: reset empties the pipeline
         a_r7_reset_clears: assert property (@(posedge clk)
            rst |=> !out_valid);
      end
      if (LATENCY == 1) begin : g_one
         // R6: single stage delays valid by one cycle
         a_r6_valid_delay: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> out_valid == $past(in_valid));
      end
   endgenerate

endmodule

bind ext_ripple_alu alu_ext_checks #(.WIDTH(WIDTH), .LATENCY(LATENCY)) i_checks (
   .clk        (clk),
   .rst        (rst),
   .in_valid   (in_valid),
   .op_a       (op_a),
   .op_b       (op_b),
   .arith_mode (arith_mode),
   .sel_hi     (sel_hi),
   .sel_lo     (sel_lo),
   .out_valid  (out_valid),
   .comb_f     (comb_f),
   .comb_cout  (comb_cout)
);

// File: tb/test_ext_ripple_alu.sv
module test_ext_ripple_alu;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [8:0] exp;
      string      tag;
   } item_t;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic [7:0] a = '0;
   logic [7:0] b = '0;
   logic       m = 1'b0;
   logic       s1 = 1'b0;
   logic       s0 = 1'b0;

   logic       n_valid, w_valid, n_cout, w_cout;
   logic [3:0] n_f;
   logic [7:0] w_f;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   item_t qn[$];
   item_t qw[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   // narrow, combinational, plain gates
   ext_ripple_alu #(.WIDTH(4), .LATENCY(0), .GATE_STYLE(0)) i_ext_ripple_alu (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(a[3:0]), .op_b(b[3:0]),
      .arith_mode(m), .sel_hi(s1), .sel_lo(s0),
      .out_valid(n_valid), .result(n_f), .carry_out(n_cout));

   // wide, two stages, majority gates
   ext_ripple_alu #(.WIDTH(8), .LATENCY(2), .GATE_STYLE(1)) i_ext_ripple_alu_w8 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(a), .op_b(b),
      .arith_mode(m), .sel_hi(s1), .sel_lo(s0),
      .out_valid(w_valid), .result(w_f), .carry_out(w_cout));

   function automatic logic [8:0] model(int w, logic [7:0] aa, logic [7:0] bb,
                                        logic mm, logic [1:0] op);
      int mask = (1 << w) - 1;
      int av = int'(aa) & mask;
      int bv = int'(bb) & mask;
      int r;
      if (mm) begin
         case (op)
            2'b00: r = av + mask;
            2'b01: r = av + bv;
            2'b10: r = av + ((~bv) & mask) + 1;
            default: r = av + 1;
         endcase
         return {1'b0, 8'(r & mask)} | (((r >> w) & 1) != 0 ? 9'h100 : 9'h000);
      end
      case (op)
         2'b00: r = (~av) & mask;
         2'b01: r = av & bv;
         2'b10: r = av;
         default: r = av | bv;
      endcase
      return {1'b0, 8'(r)};
   endfunction

   task automatic check(bit ok, string tag, logic [8:0] act, logic [8:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic drive(logic [7:0] aa, logic [7:0] bb, logic mm, logic [1:0] op);
      item_t it;
      @(posedge clk);
      #1;
      a = aa; b = bb; m = mm; {s1, s0} = op; in_valid = 1'b1;
      it.tag = mm ? "R2 R3 R1" : "R4 R1";
      it.exp = model(4, aa, bb, mm, op);
      qn.push_back(it);
      it.tag = mm ? "R2 R3 R5 R8" : "R4 R5 R8";
      it.exp = model(8, aa, bb, mm, op);
      qw.push_back(it);
   endtask

   task automatic idle();
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   // monitor / scoreboard
   initial begin
      item_t it;
      forever begin
         @(negedge clk);
         if (!rst && n_valid) begin
            if (qn.size() == 0) check(0, "R8 narrow extra", 9'h0, 9'h0);
            else begin
               it = qn.pop_front();
               check({n_cout, 4'h0, n_f} == {it.exp[8], 4'h0, it.exp[3:0]}, it.tag,
                     {n_cout, 4'h0, n_f}, {it.exp[8], 4'h0, it.exp[3:0]});
            end
         end
         if (!rst && w_valid) begin
            if (qw.size() == 0) check(0, "R8 wide extra", 9'h0, 9'h0);
            else begin
               it = qw.pop_front();
               check({w_cout, w_f} == it.exp, it.tag, {w_cout, w_f}, it.exp);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R7: hold reset with valid traffic, pipeline stays empty
      in_valid = 1'b1; a = 8'hFF; b = 8'hFF; m = 1'b1; {s1, s0} = 2'b01;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(!w_valid && w_f == 8'h00 && !w_cout, "R7 reset state",
            {w_cout, w_f}, 9'h000);
      in_valid = 1'b0;
      @(posedge clk); #1 rst = 1'b0;

      // R6: latency of the two-stage instance
      drive(8'h05, 8'h03, 1'b1, 2'b01);
      idle();
      @(negedge clk);
      check(!w_valid, "R6 not yet valid", {8'h0, w_valid}, 9'h0);
      @(negedge clk);
      check(w_valid && {w_cout, w_f} == 9'h008, "R6 valid after LATENCY",
            {w_cout, w_f}, 9'h008);
      repeat (3) idle();

      // corner cases of R3 on the narrow instance
      drive(8'h00, 8'h00, 1'b1, 2'b00);  // 0-1 -> F, no carry
      drive(8'h0F, 8'h00, 1'b1, 2'b11);  // F+1 -> 0, carry
      drive(8'h03, 8'h03, 1'b1, 2'b10);  // A==B, carry
      drive(8'h02, 8'h03, 1'b1, 2'b10);  // A<B, borrow

      // R1 R2 R3 R4: exhaustive narrow sweep, back-to-back (R8)
      for (int mm = 0; mm < 2; mm++)
         for (int op = 0; op < 4; op++)
            for (int aa = 0; aa < 16; aa++)
               for (int bb = 0; bb < 16; bb++)
                  drive(8'(aa | (bb << 4)), 8'(bb | (aa << 4)), mm[0], op[1:0]);

      // random wide traffic with idle gaps
      for (int n = 0; n < 3000; n++) begin
         drive(8'($urandom), 8'($urandom), 1'($urandom), 2'($urandom));
         if (($urandom % 8) == 0) idle();
      end
      idle();
      repeat (6) @(posedge clk);
      @(negedge clk);
      check(qn.size() == 0 && qw.size() == 0, "R8 all results delivered",
            9'(qn.size() + qw.size()), 9'h0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule